// File: doc/BRIEF.md
# ADC Conversion Record FIFO

This block buffers conversion records produced by an analog-to-digital converter until software collects them. Each record carries a 12-bit result, an invalid marker, a 2-bit code telling what started the conversion, and a 5-bit channel number. Sixteen records can be held. The block keeps an empty flag, a full flag and a sticky overrun flag. A clear strobe empties the buffer. A programmable fill level raises a sticky level flag.

Software reads the oldest record as a 32-bit word through a read strobe with four byte-lane enables. Only an access that includes the top byte lane removes the record from the buffer. This allows the low half, which holds the channel and status fields, to be inspected without consuming the record. A placement select moves the result field four bits toward the LSB. When the converter produces a record while the buffer is full and no record is leaving, the new record is discarded and the stored records are kept.

Top module: `adc_rec_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, ovr_o=0, lvl_o=0 and irq_o=0.
- R2: Records come out in the order they were written. Up to 16 records are held. full_o is 1 exactly when 16 records are held, and empty_o is 1 exactly when none are held.
- R3: A write while 16 records are held, with no pop in the same cycle, discards the new record, leaves the stored records unchanged and sets the sticky overrun flag on the next cycle.
- R4: A write and a pop in the same cycle while full both take effect. The count stays at 16 and no overrun is flagged.
- R5: An overrun-flag write with data 0 clears the flag, and a write with data 1 leaves it unchanged. If an overrun occurs in the same cycle as a clearing write, the flag ends up set.
- R6: While rd_rmw_i is 1, ovr_o reads 1 whatever the flag holds.
- R7: clr_i empties the buffer and clears the level flag in the next cycle. A write or pop in the same cycle is discarded. clr_i does not change the overrun flag.
- R8: With threshold N on thr_i (0..15), the level flag lvl_o sets in the cycle after a write raises the count from N to N+1. It stays set until lvl_ack_i or clr_i. A new hit in the same cycle as lvl_ack_i wins over the acknowledge.
- R9: With shift_sel_i=0, the read word holds the result at bits 31:20, the invalid bit at bit 12, the start code at bits 9:8 and the channel at bits 4:0. All other bits are 0.
- R10: With shift_sel_i=1, the result is at bits 27:16 and the lower 16 bits are unchanged from R9.
- R11: A read pops the oldest record only when rd_be_i[3] (byte lane for bits 31:24) is 1. Reads with rd_be_i[3]=0 leave the buffer unchanged.
- R12: When the buffer is empty, rd_data_o is 32'h0000_1000 (only the invalid bit set). A read of an empty buffer changes nothing.
- R13: irq_o is 1 exactly when the overrun flag is set and ovr_ie_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Record write strobe from the converter |
| wr_result_i | input | 12 | Conversion result |
| wr_invalid_i | input | 1 | Record invalid marker |
| wr_src_i | input | 2 | Start-cause code |
| wr_chan_i | input | 5 | Channel number |
| clr_i | input | 1 | Clear strobe, empties the buffer |
| rd_en_i | input | 1 | Read strobe |
| rd_be_i | input | 4 | Byte-lane enables of the read, bit 3 = bits 31:24 |
| rd_rmw_i | input | 1 | Current read is the read phase of a read-modify-write |
| shift_sel_i | input | 1 | Result placement select |
| thr_i | input | 4 | Fill threshold N, level flag at N+1 records |
| lvl_ack_i | input | 1 | Clears the level flag |
| ovr_wr_i | input | 1 | Write strobe to the overrun flag |
| ovr_wdata_i | input | 1 | Value written to the overrun flag (0 clears) |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| rd_data_o | output | 32 | Oldest record as a read word |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| ovr_o | output | 1 | Overrun flag as read |
| lvl_o | output | 1 | Level flag |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The assertions assume that strobes are single-cycle decisions sampled at the rising edge. They also assume that thr_i is held stable while records are being written, because the level check compares the live count against the live threshold. The stimulus changes every input only on the falling edge. It changes thr_i only while the buffer is idle, and it forces the corner cases on purpose: writes into a full buffer, writes paired with pops at full, clear strobes that collide with writes, and flag writes that collide with an overrun.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int RES_W = 12;
  localparam int SRC_W = 2;
  localparam int CH_W  = 5;

  // word layout
  localparam int RES_LSB_HI = 20;
  localparam int RES_LSB_LO = 16;
  localparam int INV_BIT    = 12;
  localparam int SRC_LSB    = 8;
  localparam int CH_LSB     = 0;

  typedef struct packed {
    logic [RES_W-1:0] result;
    logic             invalid;
    logic [SRC_W-1:0] src;
    logic [CH_W-1:0]  chan;
  } adc_rec_t;
endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  adc_rec_t         rec_i,
  input  logic             pop_i,
  input  logic             clr_i,
  output adc_rec_t         head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             push_ok_o,
  output logic             drop_o
);
  adc_rec_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_full, is_empty, pop_ok;

  assign is_full   = (cnt_q == CNT_W'(DEPTH));
  assign is_empty  = (cnt_q == '0);
  assign pop_ok    = pop_i && !clr_i && !is_empty;
  assign push_ok_o = push_i && !clr_i && (!is_full || pop_ok);
  assign drop_o    = push_i && !clr_i && is_full && !pop_ok;
  assign head_o    = mem_q[rptr_q];
  assign count_o   = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok_o) wptr_q <= nxt(wptr_q);
      if (pop_ok)    rptr_q <= nxt(rptr_q);
      if (push_ok_o && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wptr_q] <= rec_i;
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_drop_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> is_full && $stable(head_o));
  p_swap_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_full && push_i && pop_i && !clr_i) |=> is_full && !$past(drop_o));
  p_clear_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> is_empty);
endmodule

// File: rtl/adc_fifo_flags.sv
module adc_fifo_flags #(
  parameter int DEPTH = 16,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic             push_ok_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             clr_i,
  input  logic             lvl_ack_i,
  input  logic             ovr_wr_i,
  input  logic             ovr_wdata_i,
  output logic             ovr_o,
  output logic             lvl_o
);
  logic ovr_q, lvl_q, lvl_hit, ovr_clr;

  // count before the write equals N: this write stores entry N+1
  assign lvl_hit = push_ok_i && (count_i == CNT_W'(thr_i));
  assign ovr_clr = ovr_wr_i && !ovr_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      if (drop_i)       ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
      if (clr_i)          lvl_q <= 1'b0;
      else if (lvl_hit)   lvl_q <= 1'b1;
      else if (lvl_ack_i) lvl_q <= 1'b0;
    end
  end

  assign ovr_o = ovr_q;
  assign lvl_o = lvl_q;

  p_ovr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovr_q);
  p_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr) |=> ovr_q);
  p_lvl_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_hit && !clr_i) |=> lvl_q);
  p_lvl_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lvl_q);
endmodule

// File: rtl/adc_fifo_pack.sv
module adc_fifo_pack
  import adc_fifo_pkg::*;
(
  input  adc_rec_t    rec_i,
  input  logic        empty_i,
  input  logic        shift_sel_i,
  output logic [31:0] word_o
);
  always_comb begin
    word_o = '0;
    if (empty_i) begin
      word_o[INV_BIT] = 1'b1;
    end else begin
      if (shift_sel_i) word_o[RES_LSB_LO +: RES_W] = rec_i.result;
      else             word_o[RES_LSB_HI +: RES_W] = rec_i.result;
      word_o[INV_BIT]            = rec_i.invalid;
      word_o[SRC_LSB +: SRC_W]   = rec_i.src;
      word_o[CH_LSB +: CH_W]     = rec_i.chan;
    end
  end
endmodule

// File: rtl/adc_rec_fifo.sv
module adc_rec_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RES_W-1:0] wr_result_i,
  input  logic             wr_invalid_i,
  input  logic [SRC_W-1:0] wr_src_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic             clr_i,
  input  logic             rd_en_i,
  input  logic [3:0]       rd_be_i,
  input  logic             rd_rmw_i,
  input  logic             shift_sel_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             lvl_ack_i,
  input  logic             ovr_wr_i,
  input  logic             ovr_wdata_i,
  input  logic             ovr_ie_i,
  output logic [31:0]      rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovr_o,
  output logic             lvl_o,
  output logic             irq_o
);
  adc_rec_t         wrec, head;
  logic [CNT_W-1:0] count;
  logic             push_ok, drop, pop, ovr_flag;

  assign wrec = '{result: wr_result_i, invalid: wr_invalid_i,
                  src: wr_src_i, chan: wr_chan_i};
  assign pop  = rd_en_i && rd_be_i[3];

  adc_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(wr_en_i), .rec_i(wrec), .pop_i(pop), .clr_i,
    .head_o(head), .count_o(count), .push_ok_o(push_ok), .drop_o(drop)
  );

  adc_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni,
    .drop_i(drop), .push_ok_i(push_ok), .count_i(count), .thr_i,
    .clr_i, .lvl_ack_i, .ovr_wr_i, .ovr_wdata_i,
    .ovr_o(ovr_flag), .lvl_o
  );

  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_W'(DEPTH));

  adc_fifo_pack u_pack (
    .rec_i(head), .empty_i(empty_o), .shift_sel_i, .word_o(rd_data_o)
  );

  assign ovr_o = ovr_flag | rd_rmw_i;
  assign irq_o = ovr_flag & ovr_ie_i;

  p_irq_cause_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ovr_ie_i);
  p_empty_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_en_i) |=> empty_o);
  p_lane_nopop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_be_i[3] && !wr_en_i && !clr_i) |=> $stable(count));
endmodule

// File: tb/adc_rec_fifo_bench.sv
`timescale 1ns/1ps
module adc_rec_fifo_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 0, wr_invalid_i = 0, clr_i = 0, rd_en_i = 0, rd_rmw_i = 0;
  logic        shift_sel_i = 0, lvl_ack_i = 0, ovr_wr_i = 0, ovr_wdata_i = 0, ovr_ie_i = 0;
  logic [11:0] wr_result_i = 0;
  logic [1:0]  wr_src_i = 0;
  logic [4:0]  wr_chan_i = 0;
  logic [3:0]  rd_be_i = 0, thr_i = 4'd15;
  logic [31:0] rd_data_o;
  logic        empty_o, full_o, ovr_o, lvl_o, irq_o;

  int total = 0, bad = 0;
  string cur_req = "R1";
  logic [19:0] q[$];
  logic ovr_m = 0, lvl_m = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  adc_rec_fifo u_adc_rec_fifo (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w = 32'h0;
    logic [19:0] r;
    if (q.size() == 0) return 32'h0000_1000;
    r = q[0];
    if (shift_sel_i) w[27:16] = r[19:8]; else w[31:20] = r[19:8];
    w[12]  = r[7];
    w[9:8] = r[6:5];
    w[4:0] = r[4:0];
    return w;
  endfunction

  task automatic compare();
    chk("empty", 32'(empty_o), 32'(q.size() == 0));
    chk("full",  32'(full_o),  32'(q.size() == 16));
    chk("ovr",   32'(ovr_o),   32'(ovr_m | rd_rmw_i));
    chk("lvl",   32'(lvl_o),   32'(lvl_m));
    chk("irq",   32'(irq_o),   32'(ovr_m & ovr_ie_i));
    chk("word",  rd_data_o,    exp_word());
  endtask

  task automatic model();
    int sz = q.size();
    bit pop  = rd_en_i && rd_be_i[3] && !clr_i && sz > 0;
    bit push = wr_en_i && !clr_i && (sz < 16 || pop);
    bit drop = wr_en_i && !clr_i && sz == 16 && !pop;
    bit hit  = push && (sz == int'(thr_i));
    if (clr_i) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back({wr_result_i, wr_invalid_i, wr_src_i, wr_chan_i});
    end
    if (clr_i) lvl_m = 0; else if (hit) lvl_m = 1; else if (lvl_ack_i) lvl_m = 0;
    if (drop) ovr_m = 1; else if (ovr_wr_i && !ovr_wdata_i) ovr_m = 0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk_i);
    if (rst_ni) model();
    @(negedge clk_i);
    wr_en_i = 0; rd_en_i = 0; rd_be_i = 0; clr_i = 0; rd_rmw_i = 0;
    lvl_ack_i = 0; ovr_wr_i = 0; ovr_wdata_i = 0;
  endtask

  task automatic set_wr(input int i);
    wr_en_i = 1;
    wr_result_i = 12'((i * 397 + 11) & 12'hfff);
    wr_invalid_i = 1'(i);
    wr_src_i = 2'(i % 4);
    wr_chan_i = 5'((i * 7) % 32);
  endtask

  task automatic push(input int i); set_wr(i); tick(); endtask
  task automatic pop(); rd_en_i = 1; rd_be_i = 4'hf; tick(); endtask

  initial begin
    #20000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    cur_req = "R1";
    compare(); compare();
    @(negedge clk_i); rst_ni = 1;
    tick();
    // R2 fill to 16, order preserved; R9 layout while draining
    cur_req = "R2";
    for (int i = 0; i < 16; i++) push(i);
    cur_req = "R9";
    for (int i = 0; i < 8; i++) pop();
    cur_req = "R10";
    shift_sel_i = 1;
    for (int i = 0; i < 8; i++) pop();
    shift_sel_i = 0;
    // R12 read of empty buffer
    cur_req = "R12";
    pop(); pop();
    // R8 threshold N=3: flag after 4th write, ack clears
    cur_req = "R8";
    thr_i = 4'd3;
    for (int i = 20; i < 26; i++) push(i);
    lvl_ack_i = 1; tick(); tick();
    set_wr(30); lvl_ack_i = 1; tick();
    // R7 clear with colliding write
    cur_req = "R7";
    push(31);
    clr_i = 1; set_wr(40); tick(); tick();
    thr_i = 4'd15;
    // R11 lane-only reads do not pop
    cur_req = "R11";
    push(41); push(42);
    rd_en_i = 1; rd_be_i = 4'b0111; tick();
    rd_en_i = 1; rd_be_i = 4'b0011; tick();
    rd_en_i = 1; rd_be_i = 4'b1000; tick();
    clr_i = 1; tick();
    // R3 overrun keeps data; R13 irq gating
    cur_req = "R3";
    for (int i = 50; i < 66; i++) push(i);
    push(99); push(98);
    cur_req = "R13";
    ovr_ie_i = 1; tick(); ovr_ie_i = 0; tick();
    // R6 rmw read view
    cur_req = "R6";
    rd_rmw_i = 1; tick();
    // R5 write 1 no effect, write 0 clears, set beats clear
    cur_req = "R5";
    ovr_wr_i = 1; ovr_wdata_i = 1; tick();
    ovr_wr_i = 1; ovr_wdata_i = 0; tick();
    rd_rmw_i = 1; tick();
    set_wr(97); ovr_wr_i = 1; ovr_wdata_i = 0; tick(); tick();
    ovr_wr_i = 1; tick();
    // R4 write + pop at full
    cur_req = "R4";
    set_wr(70); rd_en_i = 1; rd_be_i = 4'hf; tick();
    set_wr(71); rd_en_i = 1; rd_be_i = 4'hf; tick();
    cur_req = "R2";
    for (int i = 0; i < 17; i++) pop();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule